// File: doc/BRIEF.md
# Serial Character Receiver with Status-Tagged Queue

This block recovers characters from an asynchronous serial line. A strobe at sixteen times the bit rate paces the sampler. The sampler finds the falling edge of a start bit and checks it again half a bit later. It then reads 5 to 8 data bits, least significant first, an optional parity bit and one or two stop bits, each at the middle of its bit cell.

Every recovered character is written into a 16-deep first-in first-out queue together with four status bits: line break, overrun, parity error and framing error. The host sees the oldest entry on the read outputs at all times. It removes that entry with a one-cycle pop strobe and reads the empty and full indications to know when to fetch data.

An overrun does not take a queue slot. The character that arrives while the queue is full is dropped, and the overrun bit is set on the newest stored entry. A line held low for longer than a whole frame gives exactly one break entry. No further entry is written until the line goes high again.

Top module: `uart_rx_flagfifo`

## Requirements
- R1: After reset the queue is empty: `empty_o` is 1, `full_o` is 0, and no entry is presented.
- R2: An 8-bit frame (word-length code 3) sent least significant bit first is stored with that exact byte and all four status bits clear.
- R3: Word-length code `word_len_i` = 0, 1, 2, 3 selects 5, 6, 7, 8 data bits. The unused upper bits of the stored byte read as 0.
- R4: With `two_stop_i` = 1, both stop bits are sampled, and a low second stop bit sets the framing bit. A frame whose two stop bits are both high stores clean.
- R5: With `par_en_i` = 1, one parity bit follows the data. It is even when `par_odd_i` = 0 and odd when it is 1. A mismatch sets the parity bit of the entry and a match leaves it clear.
- R6: A stop bit sampled low sets the framing bit of the stored entry. The data byte is still stored.
- R7: A low pulse on the line that has ended by the eighth oversampling strobe is rejected as a false start, and nothing is stored.
- R8: Entries leave the queue in arrival order. `full_o` rises when 16 entries are held and `empty_o` rises once the last entry is popped. The count never exceeds 16.
- R9: A frame that completes while 16 entries are held is discarded. The most recent stored entry gets its overrun bit set, and occupancy stays at 16.
- R10: A line held low for more than one frame time stores one entry with data 0 and both the break and framing bits set. Nothing more is stored until the line returns high, and the next normal frame is then received correctly.
- R11: A pop strobe while the queue is empty has no effect. The queue stays empty and the next character is stored and read correctly.
- R12: Entry read fields are packed as {break, overrun, parity, framing, data[7:0]} on the outputs `rd_brk_o`, `rd_ovr_o`, `rd_par_o`, `rd_frm_o`, `rd_data_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idle high |
| tick_i | input | 1 | One-cycle strobe at 16 times the bit rate |
| word_len_i | input | 2 | Data bits per frame minus 5 |
| two_stop_i | input | 1 | 1 selects two stop bits |
| par_en_i | input | 1 | 1 enables the parity bit |
| par_odd_i | input | 1 | 1 selects odd parity, 0 even |
| pop_i | input | 1 | Remove the oldest entry |
| rd_data_o | output | 8 | Data byte of the oldest entry |
| rd_brk_o | output | 1 | Break bit of the oldest entry |
| rd_ovr_o | output | 1 | Overrun bit of the oldest entry |
| rd_par_o | output | 1 | Parity error bit of the oldest entry |
| rd_frm_o | output | 1 | Framing error bit of the oldest entry |
| empty_o | output | 1 | 1 when no entry is held |
| full_o | output | 1 | 1 when all 16 entries are held |

## Verification
On every cycle the embedded properties check the queue bookkeeping. Full and empty are never asserted together, and occupancy never exceeds the depth. An overrun write leaves occupancy unchanged, and a pop on an empty queue changes nothing. On the receiver side they check that a write request lasts only one cycle, that a rejected start writes nothing, and that a break entry always carries the framing bit and a zero byte.

The bench scenarios alone can show the behaviour that depends on the content of the line. This covers bit order and word length, parity in both senses, the stop-bit count, which entry receives the overrun mark, and that a long low stretch yields exactly one break entry.

// File: rtl/uart_rx_pkg.sv
// Package: shared constants and types of the serial receiver.
// Assumes a fixed oversampling ratio of 16 and at most 8 data bits.
package uart_rx_pkg;
    localparam int OSR     = 16;
    localparam int HALF    = OSR / 2;
    localparam int CNT_W   = $clog2(OSR);
    localparam int DATA_W  = 8;
    localparam int IDX_W   = $clog2(DATA_W);

    // One queue entry: status bits above the character.
    typedef struct packed {
        logic              brk;
        logic              ovr;
        logic              par;
        logic              frm;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BRKCHK,
        ST_HOLD
    } rx_state_t;
endpackage

// File: rtl/uart_rx_sync.sv
// Module: uart_rx_sync
// Brings the asynchronous line into the clock domain through a chain of
// flops. Assumes STAGES >= 2. Resets to the idle (high) level.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the line level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
// Module: uart_rx_frame
// Frame recovery. Confirms a start bit at the 8th strobe after the falling
// edge, samples each later bit after 16 strobes, and checks parity and stop
// bits. Detects a line held low beyond one frame and reports it once.
// Assumes rx_s_i is already synchronized and the settings are stable
// during a frame.
module uart_rx_frame
    import uart_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_s_i,
    input  logic       tick_i,
    input  logic [1:0] word_len_i,
    input  logic       two_stop_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    output logic       push_o,
    output rx_entry_t  entry_o
);
    rx_state_t         state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] data_q;
    logic              par_err_q;
    logic              frm_err_q;
    logic              all_low_q;
    logic              stop_idx_q;
    logic              push_q;
    rx_entry_t         entry_q;

    logic [IDX_W-1:0]  last_idx;
    logic              mid;
    logic              half;
    logic              exp_par;
    logic              fe_now;

    // Decode the per-frame limits and the sample points.
    always_comb begin
        last_idx = IDX_W'(word_len_i) + IDX_W'(4);
        mid      = tick_i && (cnt_q == CNT_W'(OSR - 1));
        half     = tick_i && (cnt_q == CNT_W'(HALF - 1));
        exp_par  = (^data_q) ^ par_odd_i;
        fe_now   = frm_err_q | ~rx_s_i;
    end

    // Frame state machine with bit sampling and entry building.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            idx_q      <= '0;
            data_q     <= '0;
            par_err_q  <= 1'b0;
            frm_err_q  <= 1'b0;
            all_low_q  <= 1'b0;
            stop_idx_q <= 1'b0;
            push_q     <= 1'b0;
            entry_q    <= '0;
        end else begin
            push_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (!rx_s_i) begin
                        state_q <= ST_START;
                        cnt_q   <= '0;
                    end
                end
                ST_START: begin
                    if (half) begin
                        if (!rx_s_i) begin
                            state_q    <= ST_DATA;
                            cnt_q      <= '0;
                            idx_q      <= '0;
                            data_q     <= '0;
                            par_err_q  <= 1'b0;
                            frm_err_q  <= 1'b0;
                            all_low_q  <= 1'b1;
                            stop_idx_q <= 1'b0;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (mid) begin
                        cnt_q         <= '0;
                        data_q[idx_q] <= rx_s_i;
                        if (rx_s_i) all_low_q <= 1'b0;
                        if (idx_q == last_idx)
                            state_q <= par_en_i ? ST_PAR : ST_STOP;
                        else
                            idx_q <= idx_q + 1'b1;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (mid) begin
                        cnt_q     <= '0;
                        par_err_q <= (rx_s_i != exp_par);
                        if (rx_s_i) all_low_q <= 1'b0;
                        state_q   <= ST_STOP;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (mid) begin
                        cnt_q <= '0;
                        if (two_stop_i && !stop_idx_q) begin
                            stop_idx_q <= 1'b1;
                            frm_err_q  <= fe_now;
                            if (rx_s_i) all_low_q <= 1'b0;
                        end else if (!rx_s_i && all_low_q) begin
                            frm_err_q <= 1'b1;
                            state_q   <= ST_BRKCHK;
                        end else begin
                            push_q  <= 1'b1;
                            entry_q <= '{brk: 1'b0, ovr: 1'b0, par: par_err_q,
                                         frm: fe_now, data: data_q};
                            state_q <= rx_s_i ? ST_IDLE : ST_HOLD;
                        end
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_BRKCHK: begin
                    if (rx_s_i) begin
                        push_q  <= 1'b1;
                        entry_q <= '{brk: 1'b0, ovr: 1'b0, par: par_err_q,
                                     frm: 1'b1, data: data_q};
                        state_q <= ST_IDLE;
                    end else if (half) begin
                        push_q  <= 1'b1;
                        entry_q <= '{brk: 1'b1, ovr: 1'b0, par: 1'b0,
                                     frm: 1'b1, data: '0};
                        state_q <= ST_HOLD;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rx_s_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign push_o  = push_q;
    assign entry_o = entry_q;

    // R2
    push_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |=> !push_o);

    // R7
    false_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && half && rx_s_i) |=> (state_q == ST_IDLE && !push_o));

    // R10
    brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_o && entry_o.brk) |-> (entry_o.frm && entry_o.data == '0));

    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !push_o);
endmodule

// File: rtl/uart_rx_fifo.sv
// Module: uart_rx_fifo
// Circular queue of status-tagged entries with a show-ahead read port.
// A write while full and not popping is dropped and marks the newest
// stored entry as overrun. Assumes DEPTH is a power of two.
module uart_rx_fifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t wr_entry_i,
    input  logic      pop_i,
    output rx_entry_t rd_entry_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_entry_t       mem_q [DEPTH];
    logic [AW-1:0]   wr_ptr_q;
    logic [AW-1:0]   rd_ptr_q;
    logic [CW-1:0]   count_q;
    logic            do_pop;
    logic            do_push;
    logic            do_mark;

    // Decide which operations take effect this cycle.
    always_comb begin
        do_pop  = pop_i && (count_q != '0);
        do_push = push_i && ((count_q != CW'(DEPTH)) || do_pop);
        do_mark = push_i && !do_push;
    end

    // Storage writes and overrun marking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (do_push) begin
            mem_q[wr_ptr_q] <= wr_entry_i;
        end else if (do_mark) begin
            mem_q[wr_ptr_q - 1'b1].ovr <= 1'b1;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            if (do_push && !do_pop)      count_q <= count_q + 1'b1;
            else if (do_pop && !do_push) count_q <= count_q - 1'b1;
        end
    end

    assign rd_entry_o = mem_q[rd_ptr_q];
    assign empty_o    = (count_q == '0);
    assign full_o     = (count_q == CW'(DEPTH));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // R8
    not_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty_o && full_o));

    // R9
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> (full_o && $stable(wr_ptr_q)));

    // R11
    idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> (empty_o && $stable(rd_ptr_q)));
endmodule

// File: rtl/uart_rx_flagfifo.sv
// Module: uart_rx_flagfifo
// Top level: synchronizer, frame recovery and status-tagged queue.
// Assumes tick_i is a one-cycle strobe at 16x the bit rate.
module uart_rx_flagfifo
    import uart_rx_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    input  logic       tick_i,
    input  logic [1:0] word_len_i,
    input  logic       two_stop_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       pop_i,
    output logic [7:0] rd_data_o,
    output logic       rd_brk_o,
    output logic       rd_ovr_o,
    output logic       rd_par_o,
    output logic       rd_frm_o,
    output logic       empty_o,
    output logic       full_o
);
    logic      rx_s;
    logic      push;
    rx_entry_t wr_entry;
    rx_entry_t rd_entry;

    uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rx_i),
        .q_o   (rx_s)
    );

    uart_rx_frame i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_s_i     (rx_s),
        .tick_i     (tick_i),
        .word_len_i (word_len_i),
        .two_stop_i (two_stop_i),
        .par_en_i   (par_en_i),
        .par_odd_i  (par_odd_i),
        .push_o     (push),
        .entry_o    (wr_entry)
    );

    uart_rx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .wr_entry_i (wr_entry),
        .pop_i      (pop_i),
        .rd_entry_o (rd_entry),
        .empty_o    (empty_o),
        .full_o     (full_o)
    );

    assign rd_data_o = rd_entry.data;
    assign rd_brk_o  = rd_entry.brk;
    assign rd_ovr_o  = rd_entry.ovr;
    assign rd_par_o  = rd_entry.par;
    assign rd_frm_o  = rd_entry.frm;
endmodule

// File: tb/test_uart_rx_flagfifo.sv
// Scoreboard bench: the driver task queues the expected entries, and the
// drain task compares them against what the design presents.
module test_uart_rx_flagfifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic [1:0] div = '0;
    logic [1:0] wl = 2'd3;
    logic       ts = 1'b0;
    logic       pen = 1'b0;
    logic       podd = 1'b0;
    logic       pop = 1'b0;
    logic [7:0] rd_data;
    logic       rd_brk, rd_ovr, rd_par, rd_frm, empty, full;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [11:0] exp_q[$];
    string       tag_q[$];

    uart_rx_flagfifo i_uart_rx_flagfifo (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick_i(tick),
        .word_len_i(wl), .two_stop_i(ts), .par_en_i(pen), .par_odd_i(podd),
        .pop_i(pop), .rd_data_o(rd_data), .rd_brk_o(rd_brk), .rd_ovr_o(rd_ovr),
        .rd_par_o(rd_par), .rd_frm_o(rd_frm), .empty_o(empty), .full_o(full)
    );

    always #5 clk = ~clk;

    // Oversampling strobe, one cycle in four, changed away from the sampling edge.
    always @(negedge clk) begin
        div  <= div + 1'b1;
        tick <= (div == 2'd3);
    end

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n) begin
            do @(posedge clk); while (!tick);
        end
    endtask

    task automatic line(input logic v, input int n);
        @(negedge clk);
        rx = v;
        wait_ticks(n);
    endtask

    // Driver: send a frame and queue the entry it should produce.
    task automatic send(input logic [7:0] d, input bit bad_par, input bit bad_s1,
                        input bit bad_s2, input bit keep, input string tag);
        int nb;
        logic [7:0] dm;
        logic pbit;
        logic fe;
        nb = 5 + int'(wl);
        dm = d & 8'((1 << nb) - 1);
        pbit = (^dm) ^ podd ^ bad_par;
        line(1'b0, 16);
        for (int i = 0; i < nb; i++) line(dm[i], 16);
        if (pen) line(pbit, 16);
        line(!bad_s1, 16);
        if (ts) line(!bad_s2, 16);
        line(1'b1, 8);
        fe = bad_s1 | (ts & bad_s2);
        if (keep) begin
            exp_q.push_back({1'b0, 1'b0, pen & bad_par, fe, dm});
            tag_q.push_back(tag);
        end
    endtask

    // Monitor: compare every stored entry with the scoreboard, then pop it.
    task automatic drain();
        logic [11:0] e;
        string t;
        @(negedge clk);
        while (!empty) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected entry", {rd_brk, rd_ovr, rd_par, rd_frm, rd_data}, 12'h000);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {rd_brk, rd_ovr, rd_par, rd_frm, rd_data}, e);
            end
            pop = 1'b1;
            @(negedge clk);
            pop = 1'b0;
            @(negedge clk);
        end
        while (exp_q.size() != 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " missing"}, 12'hFFF, e);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 empty", {11'd0, empty}, 12'd1);
        check("R1 full", {11'd0, full}, 12'd0);

        // R2 and R12: 8-bit frames, LSB first
        wl = 2'd3;
        send(8'hA5, 0, 0, 0, 1, "R2 byte A5");
        send(8'h3C, 0, 0, 0, 1, "R2 byte 3C");
        send(8'h01, 0, 0, 0, 1, "R12 field packing");
        drain();

        // R3: shorter word lengths mask upper bits
        wl = 2'd0; send(8'hFF, 0, 0, 0, 1, "R3 five bits");
        wl = 2'd1; send(8'hEA, 0, 0, 0, 1, "R3 six bits");
        wl = 2'd2; send(8'hD5, 0, 0, 0, 1, "R3 seven bits");
        drain();
        wl = 2'd3;

        // R5: parity, both senses, good and bad
        pen = 1'b1;
        podd = 1'b0; send(8'h37, 0, 0, 0, 1, "R5 even good");
        podd = 1'b1; send(8'h37, 0, 0, 0, 1, "R5 odd good");
        podd = 1'b0; send(8'h52, 1, 0, 0, 1, "R5 even bad");
        podd = 1'b1; send(8'h52, 1, 0, 0, 1, "R5 odd bad");
        drain();
        pen = 1'b0;
        podd = 1'b0;

        // R6 and R4: stop bit handling
        send(8'h6E, 0, 1, 0, 1, "R6 low stop");
        ts = 1'b1;
        send(8'h47, 0, 0, 1, 1, "R4 low second stop");
        send(8'h99, 0, 0, 0, 1, "R4 two good stops");
        drain();
        ts = 1'b0;

        // R7: short low pulse is not a start bit
        line(1'b0, 4);
        line(1'b1, 40);
        @(negedge clk);
        check("R7 glitch ignored", {11'd0, empty}, 12'd1);

        // R11: pop on empty queue
        repeat (3) begin
            @(negedge clk); pop = 1'b1;
            @(negedge clk); pop = 1'b0;
        end
        check("R11 still empty", {10'd0, empty, full}, 12'b10);
        send(8'hC3, 0, 0, 0, 1, "R11 after idle pop");
        drain();

        // R8 and R9: fill, then overrun
        for (int k = 0; k < 16; k++) send(8'(8'h10 + k), 0, 0, 0, 1, "R8 order");
        @(negedge clk);
        check("R8 full at depth", {10'd0, empty, full}, 12'b01);
        send(8'hEE, 0, 0, 0, 0, "R9 dropped");
        @(negedge clk);
        check("R9 still full", {10'd0, empty, full}, 12'b01);
        exp_q[exp_q.size() - 1][10] = 1'b1;
        tag_q[tag_q.size() - 1] = "R9 overrun mark";
        drain();
        check("R8 empty after drain", {10'd0, empty, full}, 12'b10);

        // R10: break gives a single entry, then normal reception
        line(1'b0, 400);
        line(1'b1, 32);
        exp_q.push_back({1'b1, 1'b0, 1'b0, 1'b1, 8'h00});
        tag_q.push_back("R10 break entry");
        send(8'h5A, 0, 0, 0, 1, "R10 frame after break");
        drain();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule